// File: doc/BRIEF.md
# Timer Clock Tick Generator

This block sits in front of a five-channel timer and tells each channel when to count. It runs from one peripheral clock. Two shared 8-bit prescalers divide that clock first. Channels 0 and 1 use the first prescaler, and channels 2, 3 and 4 use the second. Each channel then divides its prescaler's hit rate again by a power of two. Each channel gets a one-cycle tick strobe at the resulting rate, so a channel counts once every prescale × divide input cycles.

Software programs the stage through a small word-addressed register port with two configuration words. The word at offset 0x00 holds both prescaler fields. The word at offset 0x04 holds one 4-bit divide select per channel. A divide select stores log2 of the division minus a fixed base. The base is a parameter, and its default of 1 makes select 0 mean divide by 2. Any write to either word restarts every internal counter, so the first tick after reprogramming comes at a known time.

Top module: `timer_tick_gen`

## Requirements
- R1: During and directly after reset, both configuration words read as zero and no tick is asserted.
- R2: Word 0x00 holds the first prescaler field in bits 7:0 and the second in bits 15:8. Bits 31:16 read as zero.
- R3: Word 0x04 holds the divide select of channel c in bits 4c+3:4c. Bits 31:20 read as zero.
- R4: A prescaler field value v divides by v+1, from divide by 1 (v=0) up to divide by 256 (v=255).
- R5: Channels 0 and 1 are paced by the prescaler in bits 7:0. Channels 2, 3 and 4 are paced by the prescaler in bits 15:8.
- R6: A divide select s gives a division of 2^(s+1) while s+1 ≤ 4. Every select value from 3 to 15 gives divide by 16.
- R7: Each tick is a one-cycle pulse. Consecutive ticks of a channel are exactly P×D input cycles apart, where P is the prescaler division and D is the divider division.
- R8: A write to offset 0x00 or 0x04 restarts all counters. The clock edge that takes the write starts the count. The tick is low in the cycle right after that edge, and the first tick appears P×D cycles after it.
- R9: A write to any other offset leaves both configuration words and the tick timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr (combinational) |
| tick | output | 5 | One count-enable strobe per channel |

## Verification
Two events can fall in the same cycle: a register write, and a prescaler or divider wrap that would raise a tick. The sweep reprograms the block while counters from the previous setting are still running, so writes land at many different phases, including wrap cycles. Each such case passes only if the next tick arrives exactly P×D cycles after the write edge. A write to an unused offset is placed in the very cycle a tick is visible. The tick train that follows must keep its period.

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int NUM_CH   = 5,
  parameter int PRE_W    = 8,
  parameter int SEL_W    = 4,
  parameter int MAX_LOG2 = 4,
  parameter int DIV_BASE = 1,
  parameter int GRP0_CH  = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] tick
);

  localparam int CFG0_W = 2 * PRE_W;
  localparam int CFG1_W = NUM_CH * SEL_W;
  localparam int LG_W   = SEL_W + 1;

  logic [CFG0_W-1:0] cfg0;
  logic [CFG1_W-1:0] cfg1;
  logic [PRE_W-1:0]  pcnt [2];
  logic [1:0]        pre_hit;

  wire wr0     = wr_en && (addr == ADDR_W'(0));
  wire wr1     = wr_en && (addr == ADDR_W'(4));
  wire restart = wr0 || wr1;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata[DATA_W-1:CFG1_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0 <= '0;
      cfg1 <= '0;
    end else begin
      if (wr0) cfg0 <= wdata[CFG0_W-1:0];
      if (wr1) cfg1 <= wdata[CFG1_W-1:0];
    end
  end

  assign rdata = (addr == ADDR_W'(0)) ? DATA_W'(cfg0) :
                 (addr == ADDR_W'(4)) ? DATA_W'(cfg1) : '0;

  for (genvar p = 0; p < 2; p++) begin : g_pre
    wire [PRE_W-1:0] lim = cfg0[p*PRE_W +: PRE_W];

    assign pre_hit[p] = !restart && (pcnt[p] == lim);

    always_ff @(posedge clk) begin
      if (!rst_n || restart || pre_hit[p]) pcnt[p] <= '0;
      else                                 pcnt[p] <= pcnt[p] + 1'b1;
    end

    // R4
    presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt[p] <= lim);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;

    logic [MAX_LOG2-1:0] dcnt;
    logic [MAX_LOG2-1:0] mask;
    wire  [SEL_W-1:0]    sel = cfg1[c*SEL_W +: SEL_W];
    wire  [LG_W-1:0]     lg  = {1'b0, sel} + LG_W'(DIV_BASE);

    assign mask = (lg >= LG_W'(MAX_LOG2)) ? {MAX_LOG2{1'b1}}
                                          : MAX_LOG2'((1 << lg) - 1);

    wire ch_hit = pre_hit[GRP] && ((dcnt & mask) == mask);

    always_ff @(posedge clk) begin
      if (!rst_n || restart) dcnt <= '0;
      else if (pre_hit[GRP]) dcnt <= dcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) tick[c] <= 1'b0;
      else        tick[c] <= ch_hit;
    end

    // R7
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |=> !tick[c]);

    // R5
    tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> $past(pre_hit[GRP]));
  end

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == '0));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !restart) |=> ($stable(cfg0) && $stable(cfg1)));

endmodule

// File: tb/timer_tick_gen_test.sv
`timescale 1ns/1ps
module timer_tick_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [4:0]  tick;

  int checks = 0;
  int errors = 0;

  timer_tick_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                      .wdata(wdata), .rdata(rdata), .tick(tick));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  function automatic int ddiv(input int s);
    return (s + 1 >= 4) ? 16 : (1 << (s + 1));
  endfunction

  task automatic measure(input int p0, input int p1, input int sels[5], input int poke);
    int per[5]; int first[5]; int second[5]; int cnt[5]; int lim;
    bit prev[5];
    lim = 0;
    for (int c = 0; c < 5; c++) begin
      per[c] = ((c < 2) ? p0 : p1) * ddiv(sels[c]);
      if (2 * per[c] + 2 > lim) lim = 2 * per[c] + 2;
      first[c] = 0; second[c] = 0; cnt[c] = 0;
      prev[c] = tick[c];
      // R8: tick low right after the restarting write
      chk(tick[c] == 0, "R8 quiet after write", tick[c], 0);
    end
    for (int n = 1; n <= lim; n++) begin
      @(posedge clk); #1;
      wr_en = (n == poke);
      addr = 4'h8; wdata = 32'hFFFF_FFFF;
      for (int c = 0; c < 5; c++) begin
        if (tick[c]) begin
          cnt[c]++;
          if (cnt[c] == 1) first[c] = n;
          if (cnt[c] == 2) second[c] = n;
          if (prev[c]) chk(0, "R7 pulse width", 2, 1);
        end
        prev[c] = tick[c];
      end
    end
    wr_en = 0;
    for (int c = 0; c < 5; c++) begin
      // R4 R5 R6 R8: first tick at P*D
      chk(first[c] == per[c], "R8 first tick", first[c], per[c]);
      // R7: period P*D
      chk(second[c] - first[c] == per[c], "R7 period", second[c] - first[c], per[c]);
    end
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog: actual timeout expected completion");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pa[4]; int pb[4]; int sels[5];
    logic [31:0] w1;
    pa = '{1, 2, 4, 7};
    pb = '{3, 1, 6, 2};

    repeat (3) @(posedge clk);
    #1;
    chk(tick == 0, "R1 tick in reset", tick, 0);
    rst_n = 1;
    addr = 0; #0.1;
    chk(rdata == 0, "R1 word0 reset", rdata, 0);
    chk(tick == 0, "R1 tick after reset", tick, 0);
    addr = 4; #0.1;
    chk(rdata == 0, "R1 word1 reset", rdata, 0);

    wr(4'h0, 32'hFFFF_FFFF);
    chk(rdata == 32'h0000_FFFF, "R2 word0 readback", rdata, 32'h0000_FFFF);
    wr(4'h0, 32'h1234_A55A);
    chk(rdata == 32'h0000_A55A, "R2 word0 fields", rdata, 32'h0000_A55A);
    wr(4'h4, 32'hFFFF_FFFF);
    chk(rdata == 32'h000F_FFFF, "R3 word1 readback", rdata, 32'h000F_FFFF);
    wr(4'h4, 32'hABC5_4321);
    chk(rdata == 32'h0005_4321, "R3 word1 fields", rdata, 32'h0005_4321);

    for (int pi = 0; pi < 4; pi++) begin
      for (int s = 0; s < 16; s++) begin
        wr(4'h0, ((pb[pi] - 1) << 8) | (pa[pi] - 1));
        w1 = 0;
        for (int c = 0; c < 5; c++) begin
          sels[c] = (s + c) % 16;
          w1 |= sels[c] << (4 * c);
        end
        wr(4'h4, w1);
        chk(rdata == w1, "R3 sweep readback", rdata, w1);
        measure(pa[pi], pb[pi], sels, 0);
      end
    end

    // R4 R6: largest prescale, saturated selects
    wr(4'h0, 32'h0000_00FF);
    wr(4'h4, 32'h000F_FFFF);
    sels = '{15, 15, 15, 15, 15};
    measure(256, 1, sels, 0);

    // R9: stray write in a tick cycle
    wr(4'h0, 32'h0000_0201);
    wr(4'h4, 32'h0000_1010);
    sels = '{0, 1, 0, 1, 0};
    measure(2, 3, sels, 4);
    addr = 0; #0.1;
    chk(rdata == 32'h0000_0201, "R9 word0 kept", rdata, 32'h0000_0201);
    addr = 4; #0.1;
    chk(rdata == 32'h0000_1010, "R9 word1 kept", rdata, 32'h0000_1010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule